// File: doc/BRIEF.md
# PHY Management Bus Controller with Background Polling

This block runs the two-wire Ethernet PHY management bus: a divided management clock and one bidirectional data line, brought out here as a driven value, an output enable and a sampled input. Software reaches PHY registers through two independent command slots. Each slot holds one read or write request, starts it when its GO bit is written, and reports the result (read data and an acknowledge flag) in the same slot once the frame is over.

Whenever no command is waiting, and polling is switched on, the block reads the status register (register 1) of each PHY address in turn (0 to 31 and wrapping). It records which addresses answered in an alive vector and the link bit (bit 2 of the status data) of every address in a link vector. Each slot also carries a PHY-select word that names one PHY to watch; a change of that PHY's polled link state raises a link-change flag for the slot. Link-change and command-complete flags each have a raw view, a mask set by a set/clear register pair, and a masked view, and drive two level interrupt outputs.

Register map (4-bit word address, 32-bit data): 0 config (bits 7:0 clock divider, bit 8 poll enable); 1 alive (write 1 to clear); 2 link (read only); 3 link-change raw (bits 1:0, write 1 to clear); 4 link-change masked; 5 command-done raw (bits 1:0, write 1 to clear); 6 command-done masked; 7 mask set (write 1 sets; reads the mask: bits 1:0 command-done, bits 17:16 link-change); 8 mask clear (write 1 clears); 9 and 11 command slot 0 and 1 (bit 31 GO, bit 30 write, bit 29 ack, bits 25:21 register, bits 20:16 PHY, bits 15:0 data); 10 and 12 select word for slot 0 and 1 (bits 4:0 PHY, bit 6 link-watch enable).

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Each frame is 32 ones, then 01, then opcode 10 (read) or 01 (write), 5-bit PHY address and 5-bit register address sent MSB first, 2 turnaround bits and 16 data bits MSB first; the management clock idles low, and each of its half periods lasts divider+1 core clocks.
- R2: When a read ends, the slot's data field (bits 15:0) holds the 16 bits the PHY returned and the ack bit (bit 29) is 1 exactly when the data line was low in the second turnaround bit; an absent PHY yields ack 0 and data 16'hFFFF.
- R3: A slot's GO bit reads 1 from the write that sets it until its frame ends; any write to a slot whose GO bit is 1 leaves the slot and the bus unchanged.
- R4: At a frame boundary a pending command is served before the next poll, and slot 0 is served before slot 1 when both are pending.
- R5: An alive bit sets when a read (poll or command) of that address is acknowledged; writing 1 to a bit clears it.
- R6: With polling on, the link vector bit of each address equals bit 2 of its last polled status word if the PHY acknowledged, and 0 otherwise.
- R7: Link-change raw bit k sets when a poll of the PHY named in select word k returns a link value different from the stored one and bit 6 of that select word is 1; with bit 6 at 0 it stays clear; writing 1 clears it.
- R8: Command-done raw bit k sets when slot k's frame ends; writing 1 clears it.
- R9: The command-done interrupt is the OR of command-done raw bits under mask bits 1:0, the link interrupt the OR of link-change raw bits under mask bits 17:16; mask bits are set and cleared by writing 1 to the set or clear register.
- R10: An interrupt output, once high, stays high until its raw bit is cleared or its mask bit removed.
- R11: After reset all vectors, flags, masks and slots read 0, the interrupts are low and the bus is idle.
- R12: With polling off and no command pending, no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto the bus |
| mdio_oe | output | 1 | Data output enable |
| mdio_i | input | 1 | Data value sampled from the bus |
| link_irq | output | 1 | Masked link-change interrupt |
| user_irq | output | 1 | Masked command-done interrupt |

## Verification
The scheduling decision for the next frame, the end of a background poll and the arrival of both slot commands can meet in one cycle. The bench provokes this by writing slot 1 and then slot 0 while a poll frame is still on the bus, so both are pending when that poll ends. A bench PHY model decodes every frame from the wire; the scoreboard expects the slot 0 frame first, the slot 1 frame next, and no poll frame between them.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int N_SLOT   = 2;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int N_PHY    = 1 << ADDR_W;

    localparam logic [3:0] A_CFG     = 4'd0;
    localparam logic [3:0] A_ALIVE   = 4'd1;
    localparam logic [3:0] A_LINK    = 4'd2;
    localparam logic [3:0] A_LRAW    = 4'd3;
    localparam logic [3:0] A_LMSK    = 4'd4;
    localparam logic [3:0] A_URAW    = 4'd5;
    localparam logic [3:0] A_UMSK    = 4'd6;
    localparam logic [3:0] A_MSET    = 4'd7;
    localparam logic [3:0] A_MCLR    = 4'd8;
    localparam logic [3:0] A_SLOT0   = 4'd9;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_SLOT0 = 2'd1,
        OWN_SLOT1 = 2'd2,
        OWN_POLL  = 2'd3
    } owner_e;

    typedef struct packed {
        logic              go;
        logic              wr;
        logic              ack;
        logic [ADDR_W-1:0] reg_a;
        logic [ADDR_W-1:0] phy;
        logic [DATA_W-1:0] data;
    } slot_t;

    function automatic logic [3:0] slot_cmd_addr(input int k);
        return 4'(32'(A_SLOT0) + 2 * k);
    endfunction

    function automatic logic [3:0] slot_sel_addr(input int k);
        return 4'(32'(A_SLOT0) + 2 * k + 1);
    endfunction

    function automatic owner_e slot_owner(input int k);
        return owner_e'(2'(k + 1));
    endfunction

    function automatic slot_t slot_unpack(input logic [31:0] w);
        slot_t s;
        s.go    = w[31];
        s.wr    = w[30];
        s.ack   = 1'b0;
        s.reg_a = w[25:21];
        s.phy   = w[20:16];
        s.data  = w[15:0];
        return s;
    endfunction

    function automatic logic [31:0] slot_pack(input slot_t s);
        return {s.go, s.wr, s.ack, 3'b000, s.reg_a, s.phy, s.data};
    endfunction

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q + 1'b1;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q == div) begin
            tick  = 1'b1;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] reg_a,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(PRE_LEN + 14);
    localparam logic [IDX_W-1:0] ACK_POS  = IDX_W'(PRE_LEN + 15);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic                 mdc;
        logic                 wr;
        logic                 ack;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] sh;
        logic [DATA_W-1:0]    rdata;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.mdc   = 1'b0;
                st_d.wr    = is_wr;
                st_d.ack   = 1'b0;
                st_d.idx   = '0;
                st_d.rdata = '0;
                st_d.sh    = {{PRE_LEN{1'b1}}, 2'b01,
                              (is_wr ? 2'b01 : 2'b10), phy, reg_a,
                              (is_wr ? 2'b10 : 2'b11),
                              (is_wr ? wdata : {DATA_W{1'b1}})};
            end
        end else if (tick) begin
            if (!st_q.mdc) begin
                // rising edge: the PHY's bits are taken here
                st_d.mdc = 1'b1;
                if (!st_q.wr) begin
                    if (st_q.idx == ACK_POS)
                        st_d.ack = !mdio_i;
                    else if (st_q.idx > ACK_POS)
                        st_d.rdata = {st_q.rdata[DATA_W-2:0], mdio_i};
                end
            end else begin
                // falling edge: move on to the next bit
                st_d.mdc = 1'b0;
                if (st_q.idx == LAST_POS) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = {st_q.sh[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign ack     = st_q.ack;
    assign rdata   = st_q.rdata;
    assign mdc     = st_q.mdc;
    assign mdio_o  = st_q.sh[FRAME_LEN-1];
    assign mdio_oe = st_q.busy && (st_q.wr || (st_q.idx < TA_POS));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int PRE_LEN  = 32,
    parameter int POLL_REG = 1,
    parameter int LINK_BIT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        link_irq,
    output logic        user_irq
);

    localparam logic [ADDR_W-1:0] POLL_REG_A = ADDR_W'(POLL_REG);

    typedef struct packed {
        logic [DIV_W-1:0]              div;
        logic                          poll_en;
        logic [N_PHY-1:0]              alive;
        logic [N_PHY-1:0]              link;
        logic [N_SLOT-1:0]             lraw;
        logic [N_SLOT-1:0]             uraw;
        logic [N_SLOT-1:0]             umask;
        logic [N_SLOT-1:0]             lmask;
        slot_t [N_SLOT-1:0]            slot;
        logic [N_SLOT-1:0][ADDR_W-1:0] sel_phy;
        logic [N_SLOT-1:0]             sel_en;
        owner_e                        owner;
        logic [ADDR_W-1:0]             poll_addr;
        logic [ADDR_W-1:0]             fr_phy;
        logic                          fr_wr;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic              eng_start, eng_busy, eng_done, eng_ack, tick;
    logic [DATA_W-1:0] eng_rdata;
    logic [ADDR_W-1:0] f_reg;
    logic [DATA_W-1:0] f_wd;
    logic              new_link;
    logic              picked;

    // signals brought out for the bound checker
    logic [N_SLOT-1:0] slot_go;
    logic [1:0]        owner_cur;
    logic [N_PHY-1:0]  alive_vec;

    always_comb begin
        st_d      = st_q;
        eng_start = 1'b0;
        f_reg     = '0;
        f_wd      = '0;
        new_link  = 1'b0;
        picked    = 1'b0;

        // host writes
        if (reg_wr) begin
            case (reg_addr)
                A_CFG: begin
                    st_d.div     = reg_wdata[DIV_W-1:0];
                    st_d.poll_en = reg_wdata[8];
                end
                A_ALIVE: st_d.alive = st_q.alive & ~reg_wdata[N_PHY-1:0];
                A_LRAW:  st_d.lraw  = st_q.lraw & ~reg_wdata[N_SLOT-1:0];
                A_URAW:  st_d.uraw  = st_q.uraw & ~reg_wdata[N_SLOT-1:0];
                A_MSET: begin
                    st_d.umask = st_q.umask | reg_wdata[N_SLOT-1:0];
                    st_d.lmask = st_q.lmask | reg_wdata[16 +: N_SLOT];
                end
                A_MCLR: begin
                    st_d.umask = st_q.umask & ~reg_wdata[N_SLOT-1:0];
                    st_d.lmask = st_q.lmask & ~reg_wdata[16 +: N_SLOT];
                end
                default: ;
            endcase
            for (int k = 0; k < N_SLOT; k++) begin
                if (reg_addr == slot_cmd_addr(k) && !st_q.slot[k].go)
                    st_d.slot[k] = slot_unpack(reg_wdata);
                if (reg_addr == slot_sel_addr(k)) begin
                    st_d.sel_phy[k] = reg_wdata[ADDR_W-1:0];
                    st_d.sel_en[k]  = reg_wdata[6];
                end
            end
        end

        // frame completion: hardware sets win over same-cycle clears
        if (eng_done) begin
            if (!st_q.fr_wr && eng_ack)
                st_d.alive[st_q.fr_phy] = 1'b1;
            for (int k = 0; k < N_SLOT; k++) begin
                if (st_q.owner == slot_owner(k)) begin
                    if (!st_q.fr_wr) begin
                        st_d.slot[k].data = eng_rdata;
                        st_d.slot[k].ack  = eng_ack;
                    end
                    st_d.slot[k].go = 1'b0;
                    st_d.uraw[k]    = 1'b1;
                end
            end
            if (st_q.owner == OWN_POLL) begin
                new_link = eng_ack & eng_rdata[LINK_BIT];
                for (int k = 0; k < N_SLOT; k++) begin
                    if (st_q.sel_en[k] && st_q.sel_phy[k] == st_q.fr_phy &&
                        new_link != st_q.link[st_q.fr_phy])
                        st_d.lraw[k] = 1'b1;
                end
                st_d.link[st_q.fr_phy] = new_link;
                st_d.poll_addr         = st_q.poll_addr + 1'b1;
            end
            st_d.owner = OWN_NONE;
        end

        // dispatch at a frame boundary: lowest slot first, then a poll
        if (!eng_busy && (st_q.owner == OWN_NONE || eng_done)) begin
            for (int k = 0; k < N_SLOT; k++) begin
                if (!picked && st_d.slot[k].go) begin
                    picked      = 1'b1;
                    eng_start   = 1'b1;
                    st_d.owner  = slot_owner(k);
                    st_d.fr_phy = st_d.slot[k].phy;
                    st_d.fr_wr  = st_d.slot[k].wr;
                    f_reg       = st_d.slot[k].reg_a;
                    f_wd        = st_d.slot[k].data;
                end
            end
            if (!picked && st_q.poll_en) begin
                eng_start   = 1'b1;
                st_d.owner  = OWN_POLL;
                st_d.fr_phy = st_d.poll_addr;
                st_d.fr_wr  = 1'b0;
                f_reg       = POLL_REG_A;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // register read view
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: begin
                reg_rdata[DIV_W-1:0] = st_q.div;
                reg_rdata[8]         = st_q.poll_en;
            end
            A_ALIVE: reg_rdata = st_q.alive;
            A_LINK:  reg_rdata = st_q.link;
            A_LRAW:  reg_rdata[N_SLOT-1:0] = st_q.lraw;
            A_LMSK:  reg_rdata[N_SLOT-1:0] = st_q.lraw & st_q.lmask;
            A_URAW:  reg_rdata[N_SLOT-1:0] = st_q.uraw;
            A_UMSK:  reg_rdata[N_SLOT-1:0] = st_q.uraw & st_q.umask;
            A_MSET: begin
                reg_rdata[N_SLOT-1:0]  = st_q.umask;
                reg_rdata[16 +: N_SLOT] = st_q.lmask;
            end
            default: ;
        endcase
        for (int k = 0; k < N_SLOT; k++) begin
            if (reg_addr == slot_cmd_addr(k))
                reg_rdata = slot_pack(st_q.slot[k]);
            if (reg_addr == slot_sel_addr(k)) begin
                reg_rdata[ADDR_W-1:0] = st_q.sel_phy[k];
                reg_rdata[6]          = st_q.sel_en[k];
            end
        end
    end

    assign user_irq = |(st_q.uraw & st_q.umask);
    assign link_irq = |(st_q.lraw & st_q.lmask);

    for (genvar g = 0; g < N_SLOT; g++) begin : g_go
        assign slot_go[g] = st_q.slot[g].go;
    end
    assign owner_cur = st_q.owner;
    assign alive_vec = st_q.alive;

    mdio_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (eng_start),
        .div   (st_q.div),
        .tick  (tick)
    );

    mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (eng_start),
        .is_wr   (st_d.fr_wr),
        .phy     (st_d.fr_phy),
        .reg_a   (f_reg),
        .wdata   (f_wd),
        .mdio_i  (mdio_i),
        .busy    (eng_busy),
        .done    (eng_done),
        .ack     (eng_ack),
        .rdata   (eng_rdata),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mdc,
    input logic              eng_busy,
    input logic              eng_start,
    input logic              eng_done,
    input logic              eng_ack,
    input logic [N_SLOT-1:0] slot_go,
    input logic [1:0]        owner_cur,
    input logic [N_PHY-1:0]  alive_vec,
    input logic              reg_wr,
    input logic [3:0]        reg_addr,
    input logic              user_irq,
    input logic              link_irq
);

    // R1
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);

    // R4
    start_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);

    // R3
    go0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go[0] && !(eng_done && owner_cur == OWN_SLOT0) |=> slot_go[0]);

    // R3
    go1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go[1] && !(eng_done && owner_cur == OWN_SLOT1) |=> slot_go[1]);

    // R5
    alive_set_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alive_vec & ~$past(alive_vec)) != '0 |-> $past(eng_done) && $past(eng_ack));

    // R10
    user_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_irq && !(reg_wr && (reg_addr == A_URAW || reg_addr == A_MCLR))
        |=> user_irq);

    // R10
    link_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_irq && !(reg_wr && (reg_addr == A_LRAW || reg_addr == A_MCLR))
        |=> link_irq);

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .eng_busy  (eng_busy),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_ack   (eng_ack),
    .slot_go   (slot_go),
    .owner_cur (owner_cur),
    .alive_vec (alive_vec),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .user_irq  (user_irq),
    .link_irq  (link_irq)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    logic        link_irq, user_irq;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .link_irq(link_irq), .user_irq(user_irq)
    );

    wire line = mdio_oe ? mdio_o : mdio_i;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- PHY model: responds at addresses 3 and 9 ----------------
    logic [15:0] mem [2][32];
    bit link_up3 = 0, link_up9 = 0;

    function automatic int pidx(input logic [4:0] a);
        return (a == 5'd3) ? 0 : ((a == 5'd9) ? 1 : -1);
    endfunction

    function automatic logic [15:0] phy_val(input logic [4:0] a, input logic [4:0] r);
        if (r == 5'd1) begin
            if (a == 5'd3) return link_up3 ? 16'h780D : 16'h7809;
            return link_up9 ? 16'h780D : 16'h7809;
        end
        return mem[pidx(a)][r];
    endfunction

    typedef struct { bit wr; logic [4:0] phy; logic [4:0] rg; logic [15:0] data; } frm_t;
    frm_t expq[$];
    int poll_cnt = 0;
    int marks[$];

    initial begin
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 32; r++)
                mem[p][r] = 16'(r * 256 + p * 16 + 1);
    end

    initial begin
        forever begin
            int ones;
            logic [1:0] op;
            logic [4:0] pa, ra;
            logic [15:0] val;
            logic [15:0] wd;
            bit resp;
            ones = 0;
            forever begin
                @(posedge mdc);
                if (line) ones++;
                else if (ones >= 32) break;
                else ones = 0;
            end
            @(posedge mdc);
            if (line !== 1'b1) check_eq("R1 start bits", 32'(line), 32'd1);
            op = '0; pa = '0; ra = '0;
            for (int i = 0; i < 2; i++) begin @(posedge mdc); op = {op[0], line}; end
            for (int i = 0; i < 5; i++) begin @(posedge mdc); pa = {pa[3:0], line}; end
            for (int i = 0; i < 5; i++) begin @(posedge mdc); ra = {ra[3:0], line}; end
            if (op == 2'b10) begin
                resp = (pidx(pa) >= 0);
                val  = resp ? phy_val(pa, ra) : 16'hFFFF;
                @(negedge mdc); mdio_i = 1'b1;
                @(negedge mdc); mdio_i = resp ? 1'b0 : 1'b1;
                for (int i = 15; i >= 0; i--) begin
                    @(negedge mdc); mdio_i = val[i];
                end
                @(negedge mdc); mdio_i = 1'b1;
                wd = val;
            end else begin
                @(posedge mdc); @(posedge mdc);
                wd = '0;
                for (int i = 0; i < 16; i++) begin @(posedge mdc); wd = {wd[14:0], line}; end
                if (op == 2'b01 && pidx(pa) >= 0) mem[pidx(pa)][ra] = wd;
            end
            // monitor: polls are counted, command frames compared
            if (op == 2'b10 && ra == 5'd1) begin
                poll_cnt++;
            end else if (expq.size() == 0) begin
                check_eq("R3 unexpected command frame", {16'(op), 11'd0, pa}, 32'hFFFF_FFFF);
            end else begin
                frm_t e;
                e = expq.pop_front();
                marks.push_back(poll_cnt);
                check_eq("R1 opcode", 32'(op), e.wr ? 32'd1 : 32'd2);
                check_eq("R1 phy address", 32'(pa), 32'(e.phy));
                check_eq("R1 register address", 32'(ra), 32'(e.rg));
                if (e.wr) check_eq("R1 write data", 32'(wd), 32'(e.data));
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd(input bit w, input logic [4:0] p, input logic [4:0] r,
                                        input logic [15:0] d);
        return {1'b1, w, 4'b0000, r, p, d};
    endfunction

    task automatic push_exp(input bit w, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] d);
        frm_t f;
        f.wr = w; f.phy = p; f.rg = r; f.data = d;
        expq.push_back(f);
    endtask

    task automatic issue(input int k, input bit w, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d);
        push_exp(w, p, r, d);
        wr(4'(9 + 2 * k), cmd(w, p, r, d));
    endtask

    task automatic wait_idle(input int k);
        logic [31:0] v;
        int n;
        n = 0;
        rd(4'(9 + 2 * k), v);
        while (v[31] && n < 3000) begin
            rd(4'(9 + 2 * k), v);
            n++;
        end
        if (v[31]) check_eq("R3 GO never cleared", v, 32'd0);
    endtask

    // ---------------- test sequence ----------------
    logic [31:0] v;
    realtime t0, t1;

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        rd(4'd1, v);  check_eq("R11 alive after reset", v, 32'd0);
        rd(4'd2, v);  check_eq("R11 link after reset", v, 32'd0);
        rd(4'd9, v);  check_eq("R11 slot0 after reset", v, 32'd0);
        rd(4'd7, v);  check_eq("R11 mask after reset", v, 32'd0);
        check_eq("R11 irqs after reset", {30'd0, link_irq, user_irq}, 32'd0);

        wr(4'd0, 32'h0000_0001);   // divider 1, polling off

        // write through slot 0
        issue(0, 1'b1, 5'd3, 5'd5, 16'hA5C3);
        rd(4'd9, v); check_eq("R3 GO reads 1 while busy", 32'(v[31]), 32'd1);
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        check_eq("R1 mdc period (ns)", 32'(int'(t1 - t0)), 32'd80);
        wait_idle(0);
        rd(4'd5, v); check_eq("R8 done raw slot0", v, 32'd1);
        check_eq("R9 user_irq masked off", 32'(user_irq), 32'd0);
        wr(4'd7, 32'h0000_0001);
        check_eq("R9 user_irq after mask set", 32'(user_irq), 32'd1);
        rd(4'd6, v); check_eq("R9 masked view", v, 32'd1);
        repeat (20) @(posedge clk);
        #1 check_eq("R10 user_irq held", 32'(user_irq), 32'd1);
        wr(4'd5, 32'h0000_0001);
        check_eq("R10 user_irq after raw clear", 32'(user_irq), 32'd0);

        // read back through slot 1
        issue(1, 1'b0, 5'd3, 5'd5, 16'h0);
        wait_idle(1);
        rd(4'd11, v);
        check_eq("R2 read ack", 32'(v[29]), 32'd1);
        check_eq("R2 read data", 32'(v[15:0]), 32'h0000_A5C3);
        rd(4'd1, v); check_eq("R5 alive after ack", v, 32'h0000_0008);

        // absent PHY
        issue(0, 1'b0, 5'd20, 5'd2, 16'h0);
        wait_idle(0);
        rd(4'd9, v);
        check_eq("R2 absent ack", 32'(v[29]), 32'd0);
        check_eq("R2 absent data", 32'(v[15:0]), 32'h0000_FFFF);
        rd(4'd1, v); check_eq("R5 alive unchanged for absent", v, 32'h0000_0008);

        // write while busy is ignored
        issue(0, 1'b0, 5'd3, 5'd7, 16'h0);
        wr(4'd9, cmd(1'b1, 5'd9, 5'd4, 16'hBEEF));
        wait_idle(0);
        rd(4'd9, v);
        check_eq("R3 slot kept first command", {v[30], 6'd0, v[25:16]}, {1'b0, 6'd0, 5'd7, 5'd3});
        check_eq("R3 first read data", 32'(v[15:0]), 32'(mem[0][7]));
        repeat (300) @(posedge clk);
        check_eq("R3 no extra frame", 32'(expq.size()), 32'd0);
        check_eq("R3 second command not written", 32'(mem[1][4]), 32'(16'(4 * 256 + 16 + 1)));
        check_eq("R12 no poll frames while off", 32'(poll_cnt), 32'd0);

        // polling on, both slots raised during a poll frame
        wr(4'd10, 32'h0000_0043);      // slot 0 watches PHY 3
        wr(4'd12, 32'h0000_0049);      // slot 1 watches PHY 9
        wr(4'd7, 32'h0003_0000);       // link masks on
        link_up3 = 1;
        wr(4'd0, 32'h0000_0101);
        repeat (30) @(posedge clk);
        push_exp(1'b1, 5'd9, 5'd6, 16'h1357);
        push_exp(1'b1, 5'd3, 5'd6, 16'h2468);
        wr(4'd11, cmd(1'b1, 5'd3, 5'd6, 16'h2468));
        wr(4'd9,  cmd(1'b1, 5'd9, 5'd6, 16'h1357));
        wait_idle(0);
        wait_idle(1);
        repeat (10) @(posedge clk);
        check_eq("R4 slot0 then slot1 in order", 32'(expq.size()), 32'd0);
        if (marks.size() >= 2)
            check_eq("R4 no poll between the two commands",
                     32'(marks[marks.size()-1] - marks[marks.size()-2]), 32'd0);
        check_eq("R4 a poll preceded the commands", 32'(poll_cnt > 0), 32'd1);

        repeat (18000) @(posedge clk);
        rd(4'd2, v); check_eq("R6 link vector", v, 32'h0000_0008);
        rd(4'd1, v); check_eq("R5 alive from polls", v, 32'h0000_0208);
        rd(4'd3, v); check_eq("R7 link raw", v, 32'd1);
        check_eq("R9 link_irq", 32'(link_irq), 32'd1);
        rd(4'd4, v); check_eq("R9 link masked view", v, 32'd1);
        wr(4'd3, 32'h0000_0001);
        check_eq("R10 link_irq after clear", 32'(link_irq), 32'd0);
        wr(4'd1, 32'h0000_0200);
        rd(4'd1, v); check_eq("R5 alive write-1-clear", 32'(v[9]), 32'd0);

        link_up3 = 0;
        repeat (10000) @(posedge clk);
        rd(4'd2, v); check_eq("R6 link dropped", v, 32'd0);
        rd(4'd3, v); check_eq("R7 link raw on drop", v, 32'd1);

        wr(4'd3, 32'h0000_0003);
        wr(4'd10, 32'h0000_0003);      // slot 0 watch disabled
        link_up3 = 1;
        repeat (10000) @(posedge clk);
        rd(4'd2, v); check_eq("R6 link back up", v, 32'h0000_0008);
        rd(4'd3, v); check_eq("R7 no raw when watch disabled", v, 32'd0);

        rd(4'd5, v); check_eq("R8 both slots done raw", v, 32'd3);
        check_eq("R9 user_irq with mask bit0", 32'(user_irq), 32'd1);
        wr(4'd8, 32'h0000_0001);
        check_eq("R9 user_irq after mask clear", 32'(user_irq), 32'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule